// File: doc/BRIEF.md
# Addressed Three-Wire Control Port

This block is the control interface of a receiver chip. A host drives three wires (an enable, a serial clock and a data line) and watches one open-drain return line. Before each transfer the host clocks an 8-bit address while the enable is low. When the enable goes high, the address selects one of three transfers. Two are write transfers, each filling its own configuration word. The third is a read transfer that returns a frame of receiver status. Written words sit in a receive buffer and reach the configuration outputs only when the enable falls. The receiver logic therefore never sees a half-written word.

Between transfers, the open-drain line acts as a status pin. A 3-bit selector in the second configuration word picks what it reports: loss of synthesizer lock, a measurement-done flag, signal detection or stereo detection. Any other selector value leaves the line released. All pins are sampled by the block's own clock through synchronizers. The host's serial clock may rest at either level between transfers.

Top module: `ctl_port`

## Requirements
- R1: The last 8 bits clocked on serial-clock rising edges while the enable is low form the address, first bit as bit 0. The address is decoded when the enable rises: 8'h28 selects write word 1 (24 bits), 8'h29 selects write word 2 (16 bits), 8'h2A selects the status read.
- R2: During a write, data bits are taken on serial-clock rising edges, first bit as bit 0, and only the first bits up to the word width are kept. The configuration output keeps its old value until the enable falls and takes the new value right after.
- R3: A write with fewer bits than the word width, or a transfer under any other address, leaves both configuration words unchanged.
- R4: Writes give the same result whether the serial clock idles high or low.
- R5: The return line is released for the whole enable-high period of every transfer other than a status read.
- R6: With the enable low, the selector in word 2 bits [6:4] sets the line. 001 pulls low while `unlock` is high. 010 pulls low while the end flag is set. 101 pulls low while `sd_on` is high. 110 pulls low while `stereo_on` is high. 000, 011, 100 and 111 release the line.
- R7: A `count_done` pulse sets the end flag. Each enable rise clears it. A write to word 1 that takes its start bit (bit 20) from 0 to 1 also clears it.
- R8: In a status read, the frame is captured when the enable rises and the line stays released until the first serial-clock fall. Each fall presents the next frame bit, and a 0 bit pulls the line low. Frame bit 0 is NOT stereo_on, bit 1 is NOT sd_on, bit 2 is NOT unlock, and bits 3 to 22 are count_val[19] down to count_val[0]. After bit 22 the line is released.
- R9: After reset both configuration words are zero, the end flag is clear and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Transfer enable from the host |
| cl | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| unlock | input | 1 | Synthesizer out of lock |
| sd_on | input | 1 | Station detected |
| stereo_on | input | 1 | Stereo pilot detected |
| count_done | input | 1 | One-cycle pulse at the end of a frequency count |
| count_val | input | 20 | Frequency count result |
| dout_pull | output | 1 | 1 pulls the open-drain return line low |
| cfg1 | output | 24 | Committed configuration word 1 |
| cfg2 | output | 16 | Committed configuration word 2 |

## Verification
A wrong decoded address or a miscounted bit index appears on `cfg1`/`cfg2` a few clock cycles after the enable falls. A wrong selector decode or a stale end flag appears on `dout_pull` within a cycle of the status input changing, so a sweep over all selector codes and status inputs exposes it. A slipped transmit shifter corrupts the read frame from the first wrong bit onward, and comparing all 23 sampled bits against a frame built in the bench localises it.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WR1  = 2'd1,
    SEL_WR2  = 2'd2,
    SEL_RD   = 2'd3
  } sel_e;

  // Idle-time meaning of the return line: 1 means pull low.
  function automatic logic idle_pull(input logic [2:0] doc, input logic unlock,
                                     input logic flag, input logic sd,
                                     input logic st);
    case (doc)
      3'b001:  return unlock;
      3'b010:  return flag;
      3'b101:  return sd;
      3'b110:  return st;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ctl_port_sync.sv
module ctl_port_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], pin[i]};
    end
    assign lvl[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ctl_port_rx.sv
module ctl_port_rx #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1),
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          din,
  output logic [W-1:0]  word,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (take && (cnt < CW'(W))) begin
      word[cnt[IW-1:0]] <= din;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_port_tx.sv
module ctl_port_tx #(
  parameter int W = 23,
  localparam int LW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] frame,
  input  logic         adv,
  output logic         bit_vld,
  output logic         bit_val
);
  logic [W-1:0]  sr;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      left    <= '0;
      bit_vld <= 1'b0;
      bit_val <= 1'b1;
    end else if (load) begin
      sr      <= frame;
      left    <= LW'(W);
      bit_vld <= 1'b0;
    end else if (adv) begin
      if (left != '0) begin
        bit_val <= sr[0];
        sr      <= {1'b0, sr[W-1:1]};
        left    <= left - 1'b1;
        bit_vld <= 1'b1;
      end else begin
        bit_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_port_pkg::*;
#(
  parameter int          CFG1_W      = 24,
  parameter int          CFG2_W      = 16,
  parameter int          CNT_W       = 20,
  parameter int          CTE_POS     = 20,
  parameter int          DOC_POS     = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ADDR_WR1    = 8'h28,
  parameter logic [7:0]  ADDR_WR2    = 8'h29,
  parameter logic [7:0]  ADDR_RD     = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              cl,
  input  logic              di,
  input  logic              unlock,
  input  logic              sd_on,
  input  logic              stereo_on,
  input  logic              count_done,
  input  logic [CNT_W-1:0]  count_val,
  output logic              dout_pull,
  output logic [CFG1_W-1:0] cfg1,
  output logic [CFG2_W-1:0] cfg2
);
  localparam int RX_W    = (CFG1_W > CFG2_W) ? CFG1_W : CFG2_W;
  localparam int RXC_W   = $clog2(RX_W + 1);
  localparam int FRAME_W = CNT_W + 3;

  function automatic sel_e decode_sel(input logic [7:0] a);
    if (a == ADDR_WR1) return SEL_WR1;
    if (a == ADDR_WR2) return SEL_WR2;
    if (a == ADDR_RD)  return SEL_RD;
    return SEL_NONE;
  endfunction

  // Frame bit 0 leaves first; counter goes out MSB first after three flags.
  function automatic logic [FRAME_W-1:0] build_frame(
      input logic st, input logic sd, input logic ul,
      input logic [CNT_W-1:0] cnt);
    logic [FRAME_W-1:0] f;
    f[0] = ~st;
    f[1] = ~sd;
    f[2] = ~ul;
    for (int i = 0; i < CNT_W; i++) f[3+i] = cnt[CNT_W-1-i];
    return f;
  endfunction

  // Pin sampling and edge events
  logic [2:0] sync_lvl;
  logic       ce_hi, cl_hi, di_s;
  logic [1:0] prev_q;
  logic       ce_rise, ce_fall, cl_rise, cl_fall;

  ctl_port_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({di, cl, ce}), .lvl(sync_lvl)
  );
  assign {di_s, cl_hi, ce_hi} = sync_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= {cl_hi, ce_hi};
  end

  assign ce_rise = ce_hi & ~prev_q[0];
  assign ce_fall = ~ce_hi & prev_q[0];
  assign cl_rise = cl_hi & ~prev_q[1];
  assign cl_fall = ~cl_hi & prev_q[1];

  // Address phase
  logic [7:0] addr_q;
  sel_e       sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= SEL_NONE;
    end else begin
      if (cl_rise && !ce_hi) addr_q <= {di_s, addr_q[7:1]};
      if (ce_rise)           sel_q  <= decode_sel(addr_q);
    end
  end

  // Write phase
  logic [RX_W-1:0]  rx_word;
  logic [RXC_W-1:0] rx_cnt;
  logic             wr1_commit, wr2_commit, cte_start;
  logic [CFG1_W-1:0] cfg1_q;
  logic [CFG2_W-1:0] cfg2_q;

  ctl_port_rx #(.W(RX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(ce_rise), .take(cl_rise && ce_hi),
    .din(di_s), .word(rx_word), .cnt(rx_cnt)
  );

  assign wr1_commit = ce_fall && (sel_q == SEL_WR1) && (rx_cnt >= RXC_W'(CFG1_W));
  assign wr2_commit = ce_fall && (sel_q == SEL_WR2) && (rx_cnt >= RXC_W'(CFG2_W));
  assign cte_start  = wr1_commit && rx_word[CTE_POS] && !cfg1_q[CTE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= '0;
      cfg2_q <= '0;
    end else begin
      if (wr1_commit) cfg1_q <= rx_word[CFG1_W-1:0];
      if (wr2_commit) cfg2_q <= rx_word[CFG2_W-1:0];
    end
  end

  assign cfg1 = cfg1_q;
  assign cfg2 = cfg2_q;

  // Measurement-end flag
  logic end_flag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    end_flag <= 1'b0;
    else if (ce_rise || cte_start) end_flag <= 1'b0;
    else if (count_done)           end_flag <= 1'b1;
  end

  // Read phase
  logic rd_active, bit_vld, bit_val;
  assign rd_active = ce_hi && !ce_rise && (sel_q == SEL_RD);

  ctl_port_tx #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ce_rise),
    .frame(build_frame(stereo_on, sd_on, unlock, count_val)),
    .adv(cl_fall && rd_active), .bit_vld(bit_vld), .bit_val(bit_val)
  );

  // Return line
  logic [2:0] doc;
  assign doc = cfg2_q[DOC_POS +: 3];

  always_comb begin
    if (ce_hi) dout_pull = rd_active && bit_vld && !bit_val;
    else       dout_pull = idle_pull(doc, unlock, end_flag, sd_on, stereo_on);
  end

endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
  parameter int CFG1_W  = 24,
  parameter int CFG2_W  = 16,
  parameter int DOC_POS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_hi,
  input logic              ce_rise,
  input logic              rd_active,
  input logic              wr1_commit,
  input logic              wr2_commit,
  input logic [CFG1_W-1:0] cfg1,
  input logic [CFG2_W-1:0] cfg2,
  input logic              end_flag,
  input logic              dout_pull
);
  logic [2:0] doc_v;
  assign doc_v = cfg2[DOC_POS +: 3];

  a_r2_cfg1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr1_commit |=> $stable(cfg1));

  a_r2_cfg2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr2_commit |=> $stable(cfg2));

  a_r5_open_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_hi && !rd_active) |-> !dout_pull);

  a_r6_open_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_hi && (doc_v == 3'b000 || doc_v == 3'b011 || doc_v == 3'b100 ||
                doc_v == 3'b111)) |-> !dout_pull);

  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> !end_flag);

  a_r8_open_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise ##1 ce_hi |-> !dout_pull);

endmodule

bind ctl_port ctl_port_chk #(.CFG1_W(CFG1_W), .CFG2_W(CFG2_W), .DOC_POS(DOC_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_hi(ce_hi), .ce_rise(ce_rise),
  .rd_active(rd_active), .wr1_commit(wr1_commit), .wr2_commit(wr2_commit),
  .cfg1(cfg1), .cfg2(cfg2), .end_flag(end_flag), .dout_pull(dout_pull)
);

// File: tb/ctl_port_test.sv
module ctl_port_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cl = 1'b1, di = 1'b0;
  logic        unlock = 1'b0, sd_on = 1'b0, stereo_on = 1'b0, count_done = 1'b0;
  logic [19:0] count_val = '0;
  logic        dout_pull;
  logic [23:0] cfg1;
  logic [15:0] cfg2;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ctl_port uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cl(cl), .di(di),
    .unlock(unlock), .sd_on(sd_on), .stereo_on(stereo_on),
    .count_done(count_done), .count_val(count_val),
    .dout_pull(dout_pull), .cfg1(cfg1), .cfg2(cfg2)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, input bit idle_hi);
    if (idle_hi) begin
      cl = 1'b0; di = b; step(HALF);
      cl = 1'b1; step(HALF);
    end else begin
      di = b; step(HALF);
      cl = 1'b1; step(HALF);
      cl = 1'b0; step(HALF);
    end
  endtask

  task automatic write_xfer(input logic [7:0] a, input logic [31:0] d,
                            input int n, input bit idle_hi);
    logic [23:0] o1;
    logic [15:0] o2;
    o1 = cfg1;
    o2 = cfg2;
    cl = idle_hi; ce = 1'b0; step(HALF);
    for (int i = 0; i < 8; i++) clk_bit(a[i], idle_hi);
    step(HALF);
    ce = 1'b1; step(HALF);
    for (int i = 0; i < n; i++) clk_bit(d[i], idle_hi);
    step(HALF);
    chk(dout_pull == 1'b0, "R5 line open during write", {31'd0, dout_pull}, 32'd0);
    chk(cfg1 == o1 && cfg2 == o2, "R2 words held until enable falls",
        {cfg1[15:0], cfg2}, {o1[15:0], o2});
    ce = 1'b0; step(2 * HALF);
  endtask

  task automatic read_xfer(output logic [22:0] got);
    cl = 1'b1; ce = 1'b0; step(HALF);
    for (int i = 0; i < 8; i++) clk_bit(((8'h2A >> i) & 8'h01) != 0, 1'b1);
    step(HALF);
    ce = 1'b1; step(HALF);
    chk(dout_pull == 1'b0, "R8 open before first fall", {31'd0, dout_pull}, 32'd0);
    for (int i = 0; i < 23; i++) begin
      cl = 1'b0; step(HALF);
      got[i] = ~dout_pull;
      cl = 1'b1; step(HALF);
    end
    cl = 1'b0; step(HALF);
    chk(dout_pull == 1'b0, "R8 open after last bit", {31'd0, dout_pull}, 32'd0);
    cl = 1'b1; step(HALF);
    ce = 1'b0; step(2 * HALF);
  endtask

  function automatic logic [22:0] exp_frame(input logic st, input logic sd,
                                            input logic ul, input logic [19:0] c);
    logic [22:0] f;
    f = '0;
    f[0] = !st;
    f[1] = !sd;
    f[2] = !ul;
    for (int k = 0; k < 20; k++) f[22-k] = c[k];
    return f;
  endfunction

  function automatic logic exp_idle(input logic [2:0] doc, input logic ul,
                                    input logic sd, input logic st);
    if (doc == 3'd1) return ul;
    if (doc == 3'd5) return sd;
    if (doc == 3'd6) return st;
    return 1'b0;
  endfunction

  task automatic pulse_done();
    count_done = 1'b1; step(1);
    count_done = 1'b0; step(2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    step(150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [22:0] got;
    logic [19:0] cv [3];
    logic [2:0]  fl [3];
    cv[0] = 20'hABCDE; fl[0] = 3'b001;
    cv[1] = 20'h00001; fl[1] = 3'b110;
    cv[2] = 20'h80000; fl[2] = 3'b011;

    unlock = 1'b1;
    step(10);
    // R9: reset state
    chk(cfg1 == 24'd0, "R9 cfg1 reset", {8'd0, cfg1}, 32'd0);
    chk(cfg2 == 16'd0, "R9 cfg2 reset", {16'd0, cfg2}, 32'd0);
    chk(dout_pull == 1'b0, "R9 line released in reset", {31'd0, dout_pull}, 32'd0);
    rst_n = 1'b1;
    step(10);
    chk(dout_pull == 1'b0, "R9 line released after reset", {31'd0, dout_pull}, 32'd0);
    unlock = 1'b0;

    // R1 R2: word 1, clock idle high
    write_xfer(8'h28, 32'h00A5C396, 24, 1'b1);
    chk(cfg1 == 24'hA5C396, "R1 R2 word1 write", {8'd0, cfg1}, 32'h00A5C396);
    // R1 R4: word 2, clock idle low
    write_xfer(8'h29, 32'h00003C0A, 16, 1'b0);
    chk(cfg2 == 16'h3C0A, "R4 word2 write idle low", {16'd0, cfg2}, 32'h3C0A);
    // R4: word 1, clock idle low
    write_xfer(8'h28, 32'h000F1E2D, 24, 1'b0);
    chk(cfg1 == 24'h0F1E2D, "R4 word1 write idle low", {8'd0, cfg1}, 32'h000F1E2D);
    // R2: extra bits are dropped
    write_xfer(8'h28, 32'h12345678, 32, 1'b1);
    chk(cfg1 == 24'h345678, "R2 first bits kept", {8'd0, cfg1}, 32'h00345678);
    // R3: short write
    write_xfer(8'h29, 32'h0000FFFF, 15, 1'b1);
    chk(cfg2 == 16'h3C0A, "R3 short write ignored", {16'd0, cfg2}, 32'h3C0A);
    // R3: unknown address
    write_xfer(8'h55, 32'hFFFFFFFF, 24, 1'b1);
    chk(cfg1 == 24'h345678, "R3 bad address cfg1", {8'd0, cfg1}, 32'h00345678);
    chk(cfg2 == 16'h3C0A, "R3 bad address cfg2", {16'd0, cfg2}, 32'h3C0A);
    // R3: read address leaves words alone
    write_xfer(8'h2A, 32'hFFFFFFFF, 24, 1'b1);
    chk(cfg1 == 24'h345678 && cfg2 == 16'h3C0A, "R3 read address no write",
        {cfg1[15:0], cfg2}, 32'h56783C0A);

    // R6: every selector against every status combination
    for (int d = 0; d < 8; d++) begin
      write_xfer(8'h29, 32'(d) << 4, 16, 1'b1);
      for (int s = 0; s < 8; s++) begin
        unlock = s[0]; sd_on = s[1]; stereo_on = s[2];
        step(2);
        chk(dout_pull == exp_idle(3'(d), s[0], s[1], s[2]), "R6 idle selector",
            {24'(d), 5'd0, 3'(s)} | {31'd0, dout_pull} << 31,
            {31'd0, exp_idle(3'(d), s[0], s[1], s[2])});
      end
    end

    // R5: line held open during a write despite a pulling selector
    unlock = 1'b1; sd_on = 1'b0; stereo_on = 1'b0;
    write_xfer(8'h29, 32'h00000010, 16, 1'b1);
    chk(dout_pull == 1'b1, "R6 unlock pulls when idle", {31'd0, dout_pull}, 32'd1);
    write_xfer(8'h28, 32'h00000000, 24, 1'b1);
    unlock = 1'b0;

    // R7: end flag behaviour
    write_xfer(8'h29, 32'h00000020, 16, 1'b1);
    chk(dout_pull == 1'b0, "R7 flag clear before count end", {31'd0, dout_pull}, 32'd0);
    pulse_done();
    chk(dout_pull == 1'b1, "R7 flag set by count end", {31'd0, dout_pull}, 32'd1);
    write_xfer(8'h28, 32'h00100000, 24, 1'b1);
    chk(dout_pull == 1'b0, "R7 flag cleared by start bit", {31'd0, dout_pull}, 32'd0);
    pulse_done();
    chk(dout_pull == 1'b1, "R7 flag set again", {31'd0, dout_pull}, 32'd1);
    write_xfer(8'h29, 32'h00000020, 16, 1'b1);
    chk(dout_pull == 1'b0, "R7 flag cleared by enable rise", {31'd0, dout_pull}, 32'd0);
    pulse_done();
    chk(dout_pull == 1'b1, "R7 flag set third time", {31'd0, dout_pull}, 32'd1);

    // R8: status reads
    for (int p = 0; p < 3; p++) begin
      unlock = fl[p][0]; sd_on = fl[p][1]; stereo_on = fl[p][2];
      count_val = cv[p];
      step(4);
      read_xfer(got);
      chk(got == exp_frame(fl[p][2], fl[p][1], fl[p][0], cv[p]), "R8 read frame",
          {9'd0, got}, {9'd0, exp_frame(fl[p][2], fl[p][1], fl[p][0], cv[p])});
    end
    chk(cfg1 == 24'h100000 && cfg2 == 16'h0020, "R3 read leaves words",
        {cfg1[15:0], cfg2}, 32'h00000020);

    summary();
    $finish;
  end
endmodule